// File: doc/BRIEF.md
# Per-Engine Register Window Arbiter

This block guards the local register file of one processing engine that two masters share: a host port reached through a common address space, and the engine's own datapath. The host address carries an engine selector in its upper bits above a 1 KB byte window. Only accesses whose selector matches this instance's engine number are decoded. Inside the window, word-aligned offsets from zero upward map onto a parameterized array of registers. A single status register at byte offset 0x180 reports whether the latest host access was lost.

The engine side always wins. An internal read returns data in the same cycle. An internal write takes effect at the next clock edge, whatever the host is doing. When the host touches the register space in a cycle in which the engine also accesses it, the host access is discarded without any stall. A write is not performed, and a read returns no valid data. The status bit then reads 1, and host software retries until a fresh access leaves the bit at 0. Reads of the status register itself never collide and do not change the bit.

Top module: `regwin_arbiter`

## Requirements
- R1: After reset every register reads 0, the status bit is 0 and `host_rvalid` is low.
- R2: A host request whose address bits 14:10 differ from `ENGINE_ID` is ignored. It changes no register and no status bit, and it gives no `host_rvalid`.
- R3: A host access to a register or unmapped offset in the window, made in a cycle with `eng_req` high, is dropped. A write is not stored, and there is no `host_rvalid` in the following cycle.
- R4: The status bit becomes 1 after a dropped host access. It becomes 0 after a host access to a register or unmapped offset that was not dropped.
- R5: A host read of byte offset 0x180 never collides. One cycle later it returns `host_rvalid` high and the status in bit 0 of `host_rdata`, with all other bits 0. The status bit is left unchanged.
- R6: A host access that is not dropped reaches register number `host_addr[9:2]`, and `host_addr[1:0]` is ignored. A write is stored at the clock edge. A read gives `host_rvalid` high one cycle later, with the register value as it was before that edge.
- R7: An engine write is stored at the clock edge even if a host access is pending. An engine read returns `regs[eng_idx]` on `eng_rdata` in the same cycle.
- R8: A window offset other than 0x180 whose word number is `NREGS` or more is unmapped. A read of it returns 0 with `host_rvalid`, and a write to it changes nothing. It is still arbitrated like a register access.
- R9: A host write to offset 0x180 never collides. It changes neither the status bit nor any register, and it gives no `host_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, one cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host byte address: engine selector in bits 14:10, window offset in bits 9:0 |
| host_wdata | input | DATA_W | Host write data |
| host_rvalid | output | 1 | Host read data valid, one cycle after the request |
| host_rdata | output | DATA_W | Host read data |
| eng_req | input | 1 | Engine-internal access request |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_idx | input | IDX_W | Engine register number |
| eng_wdata | input | DATA_W | Engine write data |
| eng_rdata | output | DATA_W | Engine read data, same cycle |

## Verification
A random mix runs host reads and writes against engine reads and writes, with engine activity in about a third of the cycles. Host addresses fall on mapped registers, on the status offset, on unmapped offsets and on other engines' windows. This separates dropped accesses from granted ones, and out-of-window requests from in-window ones. Interleaved status reads show whether the bit follows only the latest in-window access. Later register reads expose any write that leaked through a collision. Directed cases cover the reset state, a retry sequence after a loss, writes to the status offset, the ignored low address bits, and an engine write that coincides with a host write to the same register.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    // Window layout shared by decoder, arbiter and checker
    localparam int WIN_BITS = 10;
    localparam logic [WIN_BITS-1:0] STATUS_OFS = 10'h180;

    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_REG      = 2'd1,
        ACC_STATUS   = 2'd2,
        ACC_UNMAPPED = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int ENGINE_ID = 3,
    parameter int NREGS     = 16,
    parameter int IDX_W     = 4
) (
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  reg_idx
);
    localparam int SEL_W  = ADDR_W - WIN_BITS;
    localparam int WORD_W = WIN_BITS - 2;

    logic [SEL_W-1:0]    sel;
    logic [WIN_BITS-1:0] ofs;
    logic [WORD_W-1:0]   word;

    assign sel     = host_addr[ADDR_W-1:WIN_BITS];
    assign ofs     = host_addr[WIN_BITS-1:0];
    assign word    = ofs[WIN_BITS-1:2];
    assign reg_idx = word[IDX_W-1:0];

    always_comb begin
        kind = ACC_NONE;
        if (host_req && (sel == SEL_W'(ENGINE_ID))) begin
            if (ofs == STATUS_OFS)
                kind = ACC_STATUS;
            else if (32'(word) < NREGS)
                kind = ACC_REG;
            else
                kind = ACC_UNMAPPED;
        end
    end
endmodule

// File: rtl/regwin_regfile.sv
module regwin_regfile #(
    parameter int NREGS  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] regs_q [NREGS];
    logic [DATA_W-1:0] regs_d [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_entry
        always_comb begin
            regs_d[i] = regs_q[i];
            if (wr_en && (32'(wr_idx) == i))
                regs_d[i] = wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) regs_q[i] <= '0;
            else        regs_q[i] <= regs_d[i];
        end
    end

    if (NREGS == (1 << IDX_W)) begin : g_full
        assign ra_data = regs_q[ra_idx];
        assign rb_data = regs_q[rb_idx];
    end else begin : g_partial
        assign ra_data = (32'(ra_idx) < NREGS) ? regs_q[ra_idx] : '0;
        assign rb_data = (32'(rb_idx) < NREGS) ? regs_q[rb_idx] : '0;
    end
endmodule

// File: rtl/regwin_arbiter.sv
module regwin_arbiter
    import regwin_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 32,
    parameter int NREGS     = 16,
    parameter int ENGINE_ID = 3,
    localparam int IDX_W    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic [DATA_W-1:0] eng_rdata
);
    typedef struct packed {
        logic              lost;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } arb_state_t;

    arb_state_t st_d, st_q;

    acc_kind_e         kind;
    logic [IDX_W-1:0]  host_idx;
    logic [DATA_W-1:0] host_reg_rd;
    logic              arbitrated, collide, granted;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic              lost_q;

    regwin_decode #(
        .ADDR_W(ADDR_W), .ENGINE_ID(ENGINE_ID), .NREGS(NREGS), .IDX_W(IDX_W)
    ) u_decode (
        .host_req (host_req),
        .host_addr(host_addr),
        .kind     (kind),
        .reg_idx  (host_idx)
    );

    regwin_regfile #(
        .NREGS(NREGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .ra_idx (eng_idx),
        .ra_data(eng_rdata),
        .rb_idx (host_idx),
        .rb_data(host_reg_rd)
    );

    // Engine always wins; host register-space accesses yield to it
    always_comb begin
        arbitrated = (kind == ACC_REG) || (kind == ACC_UNMAPPED);
        collide    = arbitrated && eng_req;
        granted    = arbitrated && !eng_req;

        wr_en   = 1'b0;
        wr_idx  = eng_idx;
        wr_data = eng_wdata;
        if (eng_req && eng_we) begin
            wr_en = 1'b1;
        end else if (granted && host_we && (kind == ACC_REG)) begin
            wr_en   = 1'b1;
            wr_idx  = host_idx;
            wr_data = host_wdata;
        end

        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.rdata  = '0;
        if (collide)
            st_d.lost = 1'b1;
        else if (granted)
            st_d.lost = 1'b0;

        if (granted && !host_we) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = (kind == ACC_REG) ? host_reg_rd : '0;
        end else if ((kind == ACC_STATUS) && !host_we) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = DATA_W'(st_q.lost);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rvalid = st_q.rvalid;
    assign host_rdata  = st_q.rdata;
    assign lost_q      = st_q.lost;
endmodule

// File: rtl/regwin_checker.sv
module regwin_checker
    import regwin_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 32,
    parameter int ENGINE_ID = 3,
    parameter int IDX_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rvalid,
    input logic [DATA_W-1:0] host_rdata,
    input logic              eng_req,
    input logic              eng_we,
    input logic [IDX_W-1:0]  eng_idx,
    input logic [DATA_W-1:0] eng_wdata,
    input logic [DATA_W-1:0] eng_rdata,
    input logic              lost_q
);
    localparam int SEL_W = ADDR_W - WIN_BITS;

    logic in_win, at_status, busy;
    assign in_win    = host_req && (host_addr[ADDR_W-1:WIN_BITS] == SEL_W'(ENGINE_ID));
    assign at_status = (host_addr[WIN_BITS-1:0] == STATUS_OFS);
    assign busy      = in_win && !at_status;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!host_rvalid && !lost_q));

    assert_outside_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !in_win) |=> !host_rvalid);

    assert_drop_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_req) |=> !host_rvalid);

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_req) |=> lost_q);

    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_req) |=> !lost_q);

    assert_status_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && at_status && !host_we) |=>
            (host_rvalid && (host_rdata == DATA_W'($past(lost_q))) && $stable(lost_q)));

    assert_status_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && at_status && host_we) |=> (!host_rvalid && $stable(lost_q)));

    assert_engine_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_we) ##1 (eng_req && !eng_we && (eng_idx == $past(eng_idx)))
            |-> (eng_rdata == $past(eng_wdata)));
endmodule

bind regwin_arbiter regwin_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENGINE_ID(ENGINE_ID), .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_rvalid(host_rvalid),
    .host_rdata (host_rdata),
    .eng_req    (eng_req),
    .eng_we     (eng_we),
    .eng_idx    (eng_idx),
    .eng_wdata  (eng_wdata),
    .eng_rdata  (eng_rdata),
    .lost_q     (lost_q)
);

// File: tb/regwin_arbiter_test.sv
module regwin_arbiter_test;
    localparam int ENG   = 3;
    localparam int NR    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [14:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_rvalid;
    logic [31:0] host_rdata;
    logic        eng_req = 1'b0, eng_we = 1'b0;
    logic [3:0]  eng_idx = '0;
    logic [31:0] eng_wdata = '0;
    logic [31:0] eng_rdata;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [31:0] ref_regs [NR];
    logic        ref_lost;

    always #5 clk = ~clk;

    regwin_arbiter #(.ENGINE_ID(ENG), .NREGS(NR)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .eng_req(eng_req), .eng_we(eng_we), .eng_idx(eng_idx),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
    );

    function automatic logic [14:0] mk_addr(input int eng, input int ofs);
        return {5'(eng), 10'(ofs)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic step(input logic hr, input logic hw, input logic [14:0] ha,
                        input logic [31:0] hd, input logic er, input logic ew,
                        input logic [3:0] ei, input logic [31:0] ed);
        logic in_win;
        logic [7:0] word;
        logic exp_rv;
        logic [31:0] exp_rd;
        string tag;
        host_req = hr; host_we = hw; host_addr = ha; host_wdata = hd;
        eng_req = er; eng_we = ew; eng_idx = ei; eng_wdata = ed;
        #1;
        if (er && !ew) chk("R7 engine same-cycle read", eng_rdata, ref_regs[ei]);
        in_win = hr && (ha[14:10] == 5'(ENG));
        word   = ha[9:2];
        exp_rv = 1'b0; exp_rd = '0; tag = "R2 outside window";
        if (in_win) begin
            if (ha[9:0] == 10'h180) begin
                if (!hw) begin
                    exp_rv = 1'b1; exp_rd = {31'd0, ref_lost}; tag = "R4 R5 status read";
                end else tag = "R9 status write";
            end else if (er) begin
                ref_lost = 1'b1; tag = "R3 dropped access";
            end else begin
                ref_lost = 1'b0;
                tag = (word < NR) ? "R6 granted access" : "R8 unmapped access";
                if (!hw) begin
                    exp_rv = 1'b1; exp_rd = (word < NR) ? ref_regs[word[3:0]] : '0;
                end else if (word < NR) ref_regs[word[3:0]] = hd;
            end
        end
        if (er && ew) ref_regs[ei] = ed;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0; eng_req = 1'b0;
        chk(tag, {31'd0, host_rvalid}, {31'd0, exp_rv});
        if (exp_rv) chk(tag, host_rdata, exp_rd);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic host_rd(input int ofs);
        step(1'b1, 1'b0, mk_addr(ENG, ofs), '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic host_wr(input int ofs, input logic [31:0] d, input logic er);
        step(1'b1, 1'b1, mk_addr(ENG, ofs), d, er, 1'b0, '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) ref_regs[i] = '0;
        ref_lost = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values observed while reset is held
        chk("R1 rvalid in reset", {31'd0, host_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rvalid after reset", {31'd0, host_rvalid}, 32'd0);
        host_rd(12'h180);                       // R1 status 0
        host_rd(5 * 4);                         // R1 register 0
        // R3/R4 retry: collided write then successful retry
        host_wr(2 * 4, 32'hA5A5_0001, 1'b1);
        host_rd(12'h180);
        host_rd(12'h180);                       // R5 bit unchanged by its own read
        host_rd(2 * 4);                          // dropped write left 0
        host_wr(2 * 4, 32'hA5A5_0002, 1'b0);
        host_rd(12'h180);
        host_rd(2 * 4 + 3);                      // R6 low bits ignored
        // R9: writes to the status offset
        host_wr(7 * 4, 32'h1, 1'b1);
        host_wr(12'h180, 32'h0, 1'b0);
        host_rd(12'h180);
        // R7: engine and host write same register in same cycle
        step(1'b1, 1'b1, mk_addr(ENG, 9 * 4), 32'h1111_1111, 1'b1, 1'b1, 4'd9, 32'h2222_2222);
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 4'd9, '0);
        // R8: unmapped write/read, then status clear
        host_wr(40 * 4, 32'hDEAD_BEEF, 1'b0);
        host_rd(40 * 4);
        // R2: other engine's window, including its status offset
        step(1'b1, 1'b1, mk_addr(ENG + 1, 4), 32'h5, 1'b1, 1'b0, '0, '0);
        step(1'b1, 1'b0, mk_addr(ENG + 1, 12'h180), '0, 1'b0, 1'b0, '0, '0);
        host_rd(12'h180);
        host_rd(4);
        idle();

        for (int n = 0; n < 4000; n++) begin
            int sel = $urandom % 8;
            int ofs;
            int eng = ($urandom % 8 == 0) ? ($urandom % 32) : ENG;
            if (sel < 5)       ofs = ($urandom % NR) * 4 + ($urandom % 4);
            else if (sel == 5) ofs = 12'h180;
            else if (sel == 6) ofs = (NR + ($urandom % 80)) * 4;
            else               ofs = ($urandom % 1024);
            step(($urandom % 4) != 0, $urandom % 2, mk_addr(eng, ofs), $urandom,
                 ($urandom % 3) == 0, $urandom % 2, 4'($urandom), $urandom);
        end
        for (int i = 0; i < NR; i++) host_rd(i * 4);
        host_rd(12'h180);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule